// File: doc/BRIEF.md
# Set-Clear Interprocessor Mailbox Bank

This block holds a bank of 32-bit mailboxes that cores use to signal one another. There are four cores with four mailboxes each, sixteen in total. A mailbox is numbered `core*4 + m`, where `m` is 0 to 3. A sender raises bits in a mailbox by writing through the set window. The receiver reads the mailbox and acknowledges bits by writing through the clear window. The only state is the mailbox contents, and reset clears all of it.

Two independent write ports let two agents update the bank in the same cycle. Either port may target either window. The read port is registered and is served only from the clear window; any other read address reports an error.

For every mailbox the block drives a registered pending flag that is high whenever the mailbox is nonzero. An interrupt router decodes these flags: flag `core*4+m` becomes source bit `4+m` of that core.

Top module: `mbox_bank`

## Requirements
- R1: A write to byte address `0x80 + 4*idx` (idx 0..15) ORs the write data into mailbox idx. Other mailboxes are unchanged.
- R2: A write to byte address `0xC0 + 4*idx` clears every bit of mailbox idx where the write data is 1.
- R3: A read of `0xC0 + 4*idx` returns the mailbox contents, as they stood before the edge that samples the read, on `rd_data` in the next cycle with `rd_err` = 0.
- R4: A read of the set window (`0x80`..`0xBF`) returns 0 with `rd_err` = 1 in the next cycle.
- R5: A read of an address below `0x80`, or of an address whose two low bits are nonzero, returns 0 with `rd_err` = 1. A write to such an address changes no mailbox. When `rd_en` is low, the next cycle shows `rd_data` = 0 and `rd_err` = 0.
- R6: `pend[idx]` (bit idx = core*4+m) is 1 exactly when mailbox idx is nonzero. It changes on the same edge as the mailbox contents.
- R7: When one mailbox takes a set write and a clear write in the same cycle, the clear is applied first and the set second.
- R8: While reset is asserted, all mailboxes, all `pend` bits, `rd_data` and `rd_err` are 0.
- R9: When both ports set the same mailbox in the same cycle, both data words are ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wa_en | input | 1 | Write port A valid |
| wa_addr | input | 8 | Write port A byte address |
| wa_data | input | 32 | Write port A data |
| wb_en | input | 1 | Write port B valid |
| wb_addr | input | 8 | Write port B byte address |
| wb_data | input | 32 | Write port B data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_err | output | 1 | Invalid read address, one cycle after the request |
| pend | output | 16 | Per-mailbox nonzero flags |

## Verification
The bench drives both write ports at the same mailbox, one setting and one clearing overlapping bits. A design that applied the set first would lose the newly set bits. It also has both ports set the same mailbox, where a design that picked one port would drop the other port's data. Clears that empty a mailbox completely check that `pend` falls on the same edge; a flag computed from the old contents would lag by one cycle. Reads of the set window, unaligned addresses and low addresses must return 0 with an error, and writes to those addresses must leave every mailbox unchanged.

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int NUM_CORES    = 4,
  parameter int BOX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wa_en,
  input  logic [ADDR_W-1:0]                   wa_addr,
  input  logic [DATA_W-1:0]                   wa_data,
  input  logic                                wb_en,
  input  logic [ADDR_W-1:0]                   wb_addr,
  input  logic [DATA_W-1:0]                   wb_data,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   rd_addr,
  output logic [DATA_W-1:0]                   rd_data,
  output logic                                rd_err,
  output logic [NUM_CORES*BOX_PER_CORE-1:0]   pend
);
  localparam int NBOX  = NUM_CORES * BOX_PER_CORE;
  localparam int IDX_W = $clog2(NBOX);
  localparam int WIN_B = NBOX * 4;
  localparam logic [ADDR_W-1:0] SET_BASE = ADDR_W'(2 ** (ADDR_W - 1));
  localparam logic [ADDR_W-1:0] CLR_BASE = ADDR_W'(2 ** (ADDR_W - 1) + WIN_B);

  function automatic logic in_win(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] off;
    off = a - base;
    return (a >= base) && (int'(off) < WIN_B) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] off;
    off = a - base;
    return off[IDX_W+1:2];
  endfunction

  logic [DATA_W-1:0] box [NBOX];
  logic [DATA_W-1:0] nxt [NBOX];

  wire a_set = wa_en && in_win(wa_addr, SET_BASE);
  wire a_clr = wa_en && in_win(wa_addr, CLR_BASE);
  wire b_set = wb_en && in_win(wb_addr, SET_BASE);
  wire b_clr = wb_en && in_win(wb_addr, CLR_BASE);
  wire [IDX_W-1:0] a_idx = a_set ? idx_of(wa_addr, SET_BASE) : idx_of(wa_addr, CLR_BASE);
  wire [IDX_W-1:0] b_idx = b_set ? idx_of(wb_addr, SET_BASE) : idx_of(wb_addr, CLR_BASE);
  wire r_ok = in_win(rd_addr, CLR_BASE);
  wire [IDX_W-1:0] r_idx = idx_of(rd_addr, CLR_BASE);

  for (genvar i = 0; i < NBOX; i++) begin : g_box
    logic [DATA_W-1:0] set_m, clr_m;
    assign set_m = ((a_set && a_idx == IDX_W'(i)) ? wa_data : '0)
                 | ((b_set && b_idx == IDX_W'(i)) ? wb_data : '0);
    assign clr_m = ((a_clr && a_idx == IDX_W'(i)) ? wa_data : '0)
                 | ((b_clr && b_idx == IDX_W'(i)) ? wb_data : '0);
    assign nxt[i] = (box[i] & ~clr_m) | set_m;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        box[i]  <= '0;
        pend[i] <= 1'b0;
      end else begin
        box[i]  <= nxt[i];
        pend[i] <= |nxt[i];
      end
    end

    // R6
    pend_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] == (box[i] != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      rd_data <= (rd_en && r_ok) ? box[r_idx] : '0;
      rd_err  <= rd_en && !r_ok;
    end
  end

  // R4
  set_win_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && in_win(rd_addr, SET_BASE) |=> rd_err && rd_data == '0);

  // R3
  clr_win_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && r_ok |=> !rd_err);

  // R5
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_err && rd_data == '0);

  // R6
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wa_en && !wb_en |=> $stable(pend));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> pend == '0 && !rd_err);
endmodule

// File: tb/tb_mbox_bank.sv
module tb_mbox_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wa_en = 0, wb_en = 0, rd_en = 0;
  logic [7:0]  wa_addr = 0, wb_addr = 0, rd_addr = 0;
  logic [31:0] wa_data = 0, wb_data = 0;
  logic [31:0] rd_data;
  logic        rd_err;
  logic [15:0] pend;

  int checks = 0, errors = 0;
  logic [31:0] model [16];
  logic [31:0] exp_rd;
  logic        exp_err;

  always #4 clk = ~clk;

  mbox_bank dut (.clk, .rst_n, .wa_en, .wa_addr, .wa_data, .wb_en, .wb_addr, .wb_data,
                 .rd_en, .rd_addr, .rd_data, .rd_err, .pend);

  function automatic bit is_set(input logic [7:0] a);
    return a[7:6] == 2'b10 && a[1:0] == 2'b00;
  endfunction
  function automatic bit is_clr(input logic [7:0] a);
    return a[7:6] == 2'b11 && a[1:0] == 2'b00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pend();
    logic [15:0] p;
    for (int i = 0; i < 16; i++) p[i] = model[i] != 0;
    return p;
  endfunction

  // inputs are set before the call; applies one edge and checks
  task automatic step(input string req);
    logic [31:0] clrm [16];
    logic [31:0] setm [16];
    exp_rd  = 0;
    exp_err = 0;
    if (rd_en) begin
      if (is_clr(rd_addr)) exp_rd = model[rd_addr[5:2]];
      else exp_err = 1;
    end
    for (int i = 0; i < 16; i++) begin clrm[i] = 0; setm[i] = 0; end
    if (wa_en && is_set(wa_addr)) setm[wa_addr[5:2]] |= wa_data;
    if (wa_en && is_clr(wa_addr)) clrm[wa_addr[5:2]] |= wa_data;
    if (wb_en && is_set(wb_addr)) setm[wb_addr[5:2]] |= wb_data;
    if (wb_en && is_clr(wb_addr)) clrm[wb_addr[5:2]] |= wb_data;
    @(posedge clk);
    #1;
    for (int i = 0; i < 16; i++) model[i] = (model[i] & ~clrm[i]) | setm[i];
    chk({req, " R3/R4/R5 rd_data"}, rd_data, exp_rd);
    chk({req, " R3/R4/R5 rd_err"}, 32'(rd_err), 32'(exp_err));
    chk({req, " R6 pend"}, 32'(pend), 32'(exp_pend()));
    @(negedge clk);
    wa_en = 0; wb_en = 0; rd_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    rd_en = 1; rd_addr = a;
    step(req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = 0;
    #1;
    chk("R8 pend in reset", 32'(pend), 0);
    chk("R8 rd_err in reset", 32'(rd_err), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: set mailbox 5
    wa_en = 1; wa_addr = 8'h80 + 8'd20; wa_data = 32'h0000_0101;
    step("R1 set box5");
    chk("R1 pend bit5", 32'(pend), 32'h0020);
    rd(8'hC0 + 8'd20, "R3 read box5");
    chk("R3 box5 value", rd_data, 32'h0000_0101);
    // R2: clear one bit, then the rest
    wa_en = 1; wa_addr = 8'hC0 + 8'd20; wa_data = 32'h0000_0100;
    step("R2 partial clear");
    chk("R6 still pending", 32'(pend[5]), 1);
    wa_en = 1; wa_addr = 8'hC0 + 8'd20; wa_data = 32'hFFFF_FFFF;
    step("R2 full clear");
    chk("R6 pend falls same edge", 32'(pend[5]), 0);
    // R7: set and clear same box same cycle
    wa_en = 1; wa_addr = 8'h80 + 8'd60; wa_data = 32'h0000_00F0;
    step("R1 set box15");
    wa_en = 1; wa_addr = 8'h80 + 8'd60; wa_data = 32'h0000_000F;
    wb_en = 1; wb_addr = 8'hC0 + 8'd60; wb_data = 32'h0000_00FF;
    step("R7 set after clear");
    rd(8'hFC, "R7 read box15");
    chk("R7 box15 value", rd_data, 32'h0000_000F);
    // R9: both ports set same box
    wa_en = 1; wa_addr = 8'h80; wa_data = 32'hA000_0000;
    wb_en = 1; wb_addr = 8'h80; wb_data = 32'h0000_0005;
    step("R9 dual set");
    rd(8'hC0, "R9 read box0");
    chk("R9 box0 value", rd_data, 32'hA000_0005);
    // R4 / R5 reads
    rd(8'h80, "R4 set window read");
    chk("R4 err", 32'(rd_err), 1);
    rd(8'hC2, "R5 unaligned read");
    chk("R5 err", 32'(rd_err), 1);
    rd(8'h0C, "R5 low read");
    chk("R5 low data", rd_data, 0);
    // R5 writes to invalid addresses
    wa_en = 1; wa_addr = 8'h81; wa_data = 32'hFFFF_FFFF;
    wb_en = 1; wb_addr = 8'h10; wb_data = 32'hFFFF_FFFF;
    step("R5 invalid writes");
    for (int i = 0; i < 16; i++) rd(8'hC0 + 8'(4*i), "R5 contents unchanged");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int k;
      k = $urandom_range(0, 15);
      wa_en = $urandom_range(0, 3) != 0;
      wa_addr = {1'b1, 1'($urandom_range(0, 1)), 4'(k), 2'b00};
      if ($urandom_range(0, 15) == 0) wa_addr = 8'($urandom);
      wa_data = ($urandom_range(0, 3) == 0) ? 32'(1) << $urandom_range(0, 31) : $urandom;
      k = $urandom_range(0, 15);
      wb_en = $urandom_range(0, 2) == 0;
      wb_addr = {1'b1, 1'($urandom_range(0, 1)), 4'(k), 2'b00};
      wb_data = ($urandom_range(0, 1) == 0) ? model[k] : $urandom;
      if ($urandom_range(0, 2) == 0) wb_data = 32'hFFFF_FFFF;
      rd_en = $urandom_range(0, 1);
      rd_addr = ($urandom_range(0, 7) == 0) ? 8'($urandom)
              : {2'b11, 4'($urandom_range(0, 15)), 2'b00};
      step("R1/R2/R7/R9 random");
    end

    rst_n = 0;
    #1;
    chk("R8 pend after reset", 32'(pend), 0);
    chk("R8 rd_data after reset", rd_data, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule